// File: doc/BRIEF.md
# Sequential Restoring Binary Divider

This block divides one unsigned operand by another using the long-hand shift-and-subtract method. It produces one quotient bit per clock. A start strobe captures the dividend and the divisor. The block then runs `WIDTH` iterations. In each iteration the next dividend bit moves into a partial remainder, and that remainder is compared with the divisor. When the remainder is at least the divisor, the divisor is subtracted and a 1 enters the quotient; otherwise a 0 enters the quotient.

The dividend register is reused to collect the quotient. Quotient bits enter at its low end while dividend bits leave at its high end. A one-bit staging register sits between the dividend register and the partial remainder, so the remainder register keeps its full width at the end. The subtractor is an adder that takes the complemented divisor with a carry-in of one. Its carry-out decides the quotient bit.

A three-state controller (idle, run, finish) and a down counter with a zero detector sequence the work. When the result is ready, the block raises `done` and holds it until `start` is released.

Top module: `seq_divider`

## Requirements
- R1: After reset, `done` is 0 and both `quotient` and `remainder` read 0.
- R2: For a non-zero divisor, the finished result gives `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor. For example, 140 / 9 with `WIDTH` = 8 gives quotient 15 and remainder 5. This includes dividend < divisor and dividend = divisor.
- R3: When `start` is sampled high in idle, `done` rises on the `WIDTH`-th rising edge after that edge.
- R4: `done` stays high, with stable results, for as long as `start` stays high. On the first edge where `start` is sampled low in finish, `done` falls and the block returns to idle.
- R5: While a division is running, `start` and any change on `dividend` or `divisor` are ignored. The result depends only on the operands sampled with the accepting `start`.
- R6: A zero divisor gives `quotient` all ones and `remainder` equal to the dividend, with no other indication.
- R7: In idle with `start` low, `quotient` and `remainder` keep the last result and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle; hold to keep `done` up |
| dividend | input | WIDTH | Unsigned dividend, sampled with `start` |
| divisor | input | WIDTH | Unsigned divisor, sampled with `start` |
| quotient | output | WIDTH | Quotient, valid while `done` is high |
| remainder | output | WIDTH | Remainder, valid while `done` is high |
| done | output | 1 | Result ready |

## Verification
The bench builds the block with `WIDTH` = 8. At that width the whole operand range can be reached in a short run:
- all-ones operands;
- divisors of 0 and 1;
- the worked case 140 / 9;
- several thousand random pairs.

At `WIDTH` = 8 the counter also walks its full range of seven down to zero, so the run length and the hold-and-release behaviour of `done` are exercised at their real cycle counts. Operands are scrambled while a run is in progress, which shows that only the captured values matter.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_subtractor.sv
module div_subtractor #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] diff,
    output logic             no_borrow
);

    logic [WIDTH:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic bn;
        assign bn           = ~op_b[i];
        assign diff[i]      = op_a[i] ^ bn ^ carry[i];
        assign carry[i + 1] = (op_a[i] & bn) | (carry[i] & (op_a[i] ^ bn));
    end

    // top stage: divisor bit is an implicit zero, complemented to one
    assign no_borrow = op_a[WIDTH] | carry[WIDTH];

    always_comb begin
        AST_SUB_CARRY: assert (no_borrow == (op_a >= {1'b0, op_b})); // R2
    end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic run,
    output logic fin
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        div_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  cnt_zero;

    assign cnt_zero = ~|ctl_q.cnt;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st  = ST_RUN;
                    ctl_d.cnt = LAST_STEP;
                end
            end
            ST_RUN: begin
                if (cnt_zero) ctl_d.st = ST_FIN;
                else          ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_FIN: begin
                if (!start) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load = (ctl_q.st == ST_IDLE) && start;
    assign run  = (ctl_q.st == ST_RUN);
    assign fin  = (ctl_q.st == ST_FIN);

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && start) |=> fin); // R4
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !start) |=> (!fin && !run)); // R4
    AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (run || fin)); // R5
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_zero) |=> run); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ctl_q.cnt <= LAST_STEP)); // R3

endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);

    typedef struct packed {
        logic [WIDTH-1:0] aq;     // dividend bits out, quotient bits in
        logic [WIDTH-1:0] dvs;    // held divisor
        logic [WIDTH-1:0] part;   // partial remainder
        logic             stage;  // next dividend bit on its way into part
    } dp_t;

    dp_t            dp_d, dp_q;
    logic [WIDTH:0] trial;
    logic [WIDTH-1:0] trial_diff;
    logic           fits;

    assign trial = {dp_q.part, dp_q.stage};

    div_subtractor #(.WIDTH(WIDTH)) i_sub (
        .op_a      (trial),
        .op_b      (dp_q.dvs),
        .diff      (trial_diff),
        .no_borrow (fits)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.aq    = dividend << 1;
            dp_d.stage = dividend[WIDTH-1];
            dp_d.dvs   = divisor;
            dp_d.part  = '0;
        end else if (run) begin
            dp_d.part  = fits ? trial_diff : trial[WIDTH-1:0];
            dp_d.stage = dp_q.aq[WIDTH-1];
            dp_d.aq    = (dp_q.aq << 1) | WIDTH'(fits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q.aq    <= '0;
            dp_q.dvs   <= '0;
            dp_q.part  <= '0;
            dp_q.stage <= 1'b0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient  = dp_q.aq;
    assign remainder = dp_q.part;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> ($stable(quotient) && $stable(remainder))); // R7
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dp_q.dvs == '0) |-> fits); // R6
    AST_PART_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dp_q.dvs != '0) |-> (dp_q.part < dp_q.dvs)); // R2

endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             done
);

    logic load;
    logic run;
    logic fin;

    div_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .run   (run),
        .fin   (fin)
    );

    div_datapath #(.WIDTH(WIDTH)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (run),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

    assign done = fin;

    AST_DONE_ONLY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run)); // R3

endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;

    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural model state: 0 idle, 1 running, 2 finished
    int m_state = 0;
    int m_left = 0;
    int m_q = 0;
    int m_r = 0;
    int m_b = 0;

    always #2 clk = ~clk;

    seq_divider #(.WIDTH(W)) i_seq_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0;
            m_left  = 0;
            m_q     = 0;
            m_r     = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_b = int'(divisor);
                    if (divisor == 0) begin
                        m_q = MAXV;
                        m_r = int'(dividend);
                    end else begin
                        m_q = int'(dividend) / int'(divisor);
                        m_r = int'(dividend) % int'(divisor);
                    end
                    m_left  = W;
                    m_state = 1;
                end
                1: begin
                    m_left--;
                    if (m_left == 0) m_state = 2;
                end
                default: if (!start) m_state = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(done == (m_state == 2), "R3 R4 done", int'(done), int'(m_state == 2));
            if (m_state == 2) begin
                chk(int'(quotient) == m_q, (m_b == 0) ? "R6 quotient" : "R2 R5 quotient",
                    int'(quotient), m_q);
                chk(int'(remainder) == m_r, (m_b == 0) ? "R6 remainder" : "R2 R5 remainder",
                    int'(remainder), m_r);
            end else if (m_state == 0) begin
                chk(int'(quotient) == m_q, "R7 quotient held", int'(quotient), m_q);
                chk(int'(remainder) == m_r, "R7 remainder held", int'(remainder), m_r);
            end
        end
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // keep: extra cycles start stays high after done (negative: drop at once)
    task automatic divide(input int a, input int b, input int keep);
        @(negedge clk);
        start    = 1'b1;
        dividend = W'(a);
        divisor  = W'(b);
        @(negedge clk);
        if (keep < 0) start = 1'b0;
        for (int i = 0; i < W; i++) begin
            dividend = W'($urandom);
            divisor  = W'($urandom);
            @(negedge clk);
        end
        if (keep > 0) repeat (keep) @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(quotient == '0, "R1 quotient", int'(quotient), 0);
        chk(remainder == '0, "R1 remainder", int'(remainder), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 R7 idle done", int'(done), 0);

        divide(140, 9, -1);     // R2 worked case
        divide(3, 200, 0);      // R2 dividend below divisor
        divide(77, 77, 3);      // R2 R4 equal operands, held start
        divide(200, 0, -1);     // R6 zero divisor
        divide(0, 0, 2);        // R6
        divide(MAXV, 1, -1);    // R2
        divide(MAXV, MAXV, 5);  // R4
        divide(0, 7, 0);        // R2
        divide(128, 2, -1);     // R2
        for (int i = 0; i < 2000; i++)
            divide(int'($urandom_range(MAXV)), int'($urandom_range(MAXV)),
                   int'($urandom_range(4)) - 1); // R2 R5

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule